// File: doc/BRIEF.md
# Bus-Interfaced Successive-Approximation Conversion Controller

This block is the digital half of an 8-bit successive-approximation converter that sits on a microprocessor bus. A processor starts a conversion by pulsing an active-low write strobe while the active-low chip select is held low. For as long as both are low the converter is held in reset. When the strobe is released, the controller waits a fixed number of clocks so that the asynchronous start lines up with its clock phases. It then runs a binary search over the code, one bit per clock from the most significant to the least significant bit.

During the search the controller presents a trial code to an external DAC and comparator. It reads back one bit, `cmp_below`, which is 1 when the analog input lies below the trial level. When the search ends, the code is copied into an output latch and the active-low interrupt goes low. The processor reads the result with a chip-selected read strobe. The read enables the bus drivers and also clears the interrupt.

With chip select tied low and the write strobe fed from the interrupt output, the block restarts on its own after every result and converts continuously.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, `intr_n` is 1, `data_oe` is 0, `data_out` is all zeros and `trial_code` is all zeros.
- R2: A conversion starts when `wr_n` rises while `cs_n` is low. The code it latches is the binary-search result for the comparator: each bit is kept at 1 unless `cmp_below` is 1 while that bit is under test.
- R3: A conversion makes exactly WIDTH decisions, one per clock, starting from the MSB. The first trial code is 1 in the MSB and 0 elsewhere. During the search `trial_code` is nonzero, and it is zero outside it.
- R4: While `cs_n` and `wr_n` are both low, no decision is made and `trial_code` stays zero, however long the pulse lasts.
- R5: A low pulse on `wr_n` while `cs_n` is high starts nothing and leaves `intr_n` unchanged.
- R6: The first trial code appears between ALIGN_CLKS and ALIGN_CLKS+SYNC_STAGES+4 clocks after the start strobe is released.
- R7: `data_oe` is 1 exactly while `cs_n` and `rd_n` are both low. In that window `data_out` carries the latched result. At all other times `data_out` is all zeros.
- R8: `intr_n` goes low on the clock at which a new result is latched, and never at any other time.
- R9: A read with `cs_n` low drives `intr_n` high within SYNC_STAGES+2 clocks. A read with `cs_n` high leaves `intr_n` low.
- R10: Holding `cs_n` and `wr_n` low drives `intr_n` high.
- R11: A start strobe during a search aborts it and starts over. The previously latched code stays readable until the new code is latched.
- R12: With `cs_n` tied low and `wr_n` driven from `intr_n`, the block converts continuously. Each latched code matches the ideal threshold model for the input present during that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low start strobe; low with `cs_n` holds reset, rising edge starts |
| rd_n | input | 1 | Active-low read strobe |
| cmp_below | input | 1 | Comparator: 1 when the analog input is below the trial level |
| trial_code | output | WIDTH | Trial code to the external DAC |
| data_out | output | WIDTH | Result bus value, valid while `data_oe` is 1 |
| data_oe | output | 1 | Tri-state enable for the result bus |
| intr_n | output | 1 | Active-low end-of-conversion interrupt |

## Verification
The hardest situation to reach from the ports is a restart that lands inside the bit-decision window. It must arrive after the alignment wait has ended and before the last bit has been decided. At that point the latch still holds the previous code, and the interrupt must not fire for the abandoned search. The stimulus releases a start strobe and waits past the alignment delay. It then confirms at the port that `trial_code` is nonzero before it pulses the strobe again. Reads in this window must return the earlier code, and the code returned after the interrupt must be the one for the new input. The free-running loop is also hard to reach, because it only runs once the bench feeds `intr_n` back into `wr_n`.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_ALIGN = 2'd2,
      ST_CONV  = 2'd3
   } seq_state_t;

   function automatic int idx_bits(input int w);
      return (w > 1) ? $clog2(w) : 1;
   endfunction

endpackage

// File: rtl/sarc_sync.sv
module sarc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= d;
         end
         assign q = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[STAGES-2:0], d};
         end
         assign q = s_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sarc_seq.sv
module sarc_seq #(
   parameter int WIDTH      = 8,
   parameter int ALIGN_CLKS = 8,
   parameter int IDXW       = sarc_pkg::idx_bits(WIDTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   output logic            in_conv,
   output logic            conv_en,
   output logic            last_bit,
   output logic [IDXW-1:0] bit_idx
);
   import sarc_pkg::*;

   localparam int              CNTW    = $clog2(ALIGN_CLKS + 1);
   localparam logic [IDXW-1:0] TOP_IDX = IDXW'(WIDTH - 1);

   seq_state_t      state_q;
   logic [IDXW-1:0] idx_q;
   logic            align_done;

   // phase-alignment wait: a counter when longer than one clock
   generate
      if (ALIGN_CLKS > 1) begin : g_align_cnt
         logic [CNTW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (state_q == ST_ALIGN && !hold && !align_done)
               cnt_q <= cnt_q + 1'b1;
            else
               cnt_q <= '0;
         end
         assign align_done = (cnt_q == CNTW'(ALIGN_CLKS - 1));

         // R6
         align_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q < CNTW'(ALIGN_CLKS)));
      end else begin : g_align_one
         assign align_done = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else if (hold) begin
         state_q <= ST_HOLD;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_HOLD: state_q <= ST_ALIGN;
            ST_ALIGN: begin
               if (align_done) begin
                  state_q <= ST_CONV;
                  idx_q   <= TOP_IDX;
               end
            end
            ST_CONV: begin
               if (idx_q == '0) state_q <= ST_IDLE;
               else             idx_q   <= idx_q - 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign in_conv  = (state_q == ST_CONV);
   assign conv_en  = in_conv && !hold;
   assign last_bit = conv_en && (idx_q == '0);
   assign bit_idx  = idx_q;

   // R4
   hold_no_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (state_q == ST_HOLD));

   // R3
   bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_en && idx_q != '0) |=> (in_conv && (idx_q + 1'b1) == $past(idx_q)));

endmodule

// File: rtl/sarc_reg.sv
module sarc_reg #(
   parameter int WIDTH = 8,
   parameter int IDXW  = sarc_pkg::idx_bits(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_conv,
   input  logic             conv_en,
   input  logic             cmp_below,
   input  logic [IDXW-1:0]  bit_idx,
   output logic [WIDTH-1:0] trial,
   output logic [WIDTH-1:0] decided
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] sar_q;
   logic [WIDTH-1:0] mask;

   assign mask    = ONE << bit_idx;
   assign trial   = in_conv ? (sar_q | mask) : '0;
   assign decided = cmp_below ? sar_q : (sar_q | mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sar_q <= '0;
      else if (!in_conv)
         sar_q <= '0;
      else if (conv_en)
         sar_q <= decided;
   end

   // R3
   search_from_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_conv) |-> (sar_q == '0));

endmodule

// File: rtl/sarc_port.sv
module sarc_port #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             rd_n,
   input  logic             done,
   input  logic             arm_s,
   input  logic             read_s,
   input  logic [WIDTH-1:0] new_code,
   output logic [WIDTH-1:0] data_out,
   output logic             data_oe,
   output logic             intr_n
);

   logic [WIDTH-1:0] latch_q;
   logic             intr_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    latch_q <= '0;
      else if (done) latch_q <= new_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 intr_n_q <= 1'b1;
      else if (done)              intr_n_q <= 1'b0;
      else if (arm_s || read_s)   intr_n_q <= 1'b1;
   end

   assign data_oe  = !cs_n && !rd_n;
   assign data_out = data_oe ? latch_q : '0;
   assign intr_n   = intr_n_q;

   // R11
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(latch_q));

   // R8
   intr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(intr_n_q) |-> $past(done));

   // R10
   arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_s && !done) |=> intr_n_q);

   // R9
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (read_s && !done) |=> intr_n_q);

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ALIGN_CLKS  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic             cmp_below,
   output logic [WIDTH-1:0] trial_code,
   output logic [WIDTH-1:0] data_out,
   output logic             data_oe,
   output logic             intr_n
);

   localparam int IDXW = sarc_pkg::idx_bits(WIDTH);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sar_bus_ctrl: WIDTH must be 2 or more");
      end
      if (ALIGN_CLKS < 1) begin : g_bad_align
         $error("sar_bus_ctrl: ALIGN_CLKS must be 1 or more");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("sar_bus_ctrl: SYNC_STAGES must be 4 or fewer");
      end
   endgenerate

   logic            hold_raw, read_raw;
   logic            hold_s, read_s;
   logic            in_conv, conv_en, last_bit;
   logic [IDXW-1:0] bit_idx;
   logic [WIDTH-1:0] decided;

   assign hold_raw = !cs_n && !wr_n;
   assign read_raw = !cs_n && !rd_n;

   sarc_sync #(.STAGES(SYNC_STAGES)) u_hold_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (hold_raw),
      .q     (hold_s)
   );

   sarc_sync #(.STAGES(SYNC_STAGES)) u_read_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (read_raw),
      .q     (read_s)
   );

   sarc_seq #(
      .WIDTH      (WIDTH),
      .ALIGN_CLKS (ALIGN_CLKS),
      .IDXW       (IDXW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold_s),
      .in_conv  (in_conv),
      .conv_en  (conv_en),
      .last_bit (last_bit),
      .bit_idx  (bit_idx)
   );

   sarc_reg #(
      .WIDTH (WIDTH),
      .IDXW  (IDXW)
   ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_conv   (in_conv),
      .conv_en   (conv_en),
      .cmp_below (cmp_below),
      .bit_idx   (bit_idx),
      .trial     (trial_code),
      .decided   (decided)
   );

   sarc_port #(.WIDTH(WIDTH)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .rd_n     (rd_n),
      .done     (last_bit),
      .arm_s    (hold_s),
      .read_s   (read_s),
      .new_code (decided),
      .data_out (data_out),
      .data_oe  (data_oe),
      .intr_n   (intr_n)
   );

endmodule

// File: tb/sim_sar_bus_ctrl.sv
`timescale 1ns/1ps
module sim_sar_bus_ctrl;

   localparam int W     = 8;
   localparam int SYNC  = 2;
   localparam int ALIGN = 8;
   localparam int WD    = 200000;

   logic clk = 1'b0;
   logic rst_n, cs_n, wr_drv, rd_n, sa_mode, kick_n;
   int   ana;
   logic [W-1:0] trial_code, data_out;
   logic data_oe, intr_n, wr_n, cmp_below;

   int checks = 0, errors = 0;
   int cyc = 0, tot_trials = 0, rise_cyc = 0, rise_val = 0;
   logic [W-1:0] prev_trial = '0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   // comparator threshold model: code c passes when ana+2 >= 4*c
   assign cmp_below = (ana + 2) < (int'(trial_code) * 4);
   assign wr_n = sa_mode ? (intr_n & kick_n) : wr_drv;

   sar_bus_ctrl #(.WIDTH(W), .SYNC_STAGES(SYNC), .ALIGN_CLKS(ALIGN)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .cmp_below(cmp_below), .trial_code(trial_code), .data_out(data_out),
      .data_oe(data_oe), .intr_n(intr_n)
   );

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (trial_code != '0) begin
         tot_trials <= tot_trials + 1;
         if (prev_trial == '0) begin
            rise_cyc <= cyc;
            rise_val <= int'(trial_code);
         end
      end
      prev_trial <= trial_code;
   end

   function automatic int exp_code(input int a);
      return ((a + 2) / 4 > 255) ? 255 : (a + 2) / 4;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic wait_intr_low(input string req);
      bit seen = 1'b0;
      for (int i = 0; i < 300 && !seen; i++) begin
         @(negedge clk);
         if (intr_n == 1'b0) seen = 1'b1;
      end
      if (!seen) chk(1'b0, req, 1, 0);
   endtask

   task automatic bus_read(output logic [W-1:0] val, output logic oe);
      cs_n = 1'b0; rd_n = 1'b0;
      #1;
      val = data_out; oe = data_oe;
      rd_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic arm_release(input int len);
      @(negedge clk);
      cs_n = 1'b0; wr_drv = 1'b0;
      repeat (len) @(negedge clk);
      wr_drv = 1'b1; cs_n = 1'b1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; cs_n = 1'b1; wr_drv = 1'b1; rd_n = 1'b1;
      sa_mode = 1'b0; kick_n = 1'b1; ana = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(intr_n == 1'b1, "R1 intr_n", int'(intr_n), 1);
      chk(data_oe == 1'b0, "R1 data_oe", int'(data_oe), 0);
      chk(data_out == '0, "R1 data_out", int'(data_out), 0);
      chk(trial_code == '0, "R1 trial_code", int'(trial_code), 0);
   endtask

   task automatic t_convert(input int a);
      int t0, rel, lat;
      logic [W-1:0] v; logic oe;
      ana = a;
      t0 = tot_trials;
      arm_release(4);
      rel = cyc;
      wait_intr_low("R8 no interrupt");
      @(negedge clk); #1;
      lat = rise_cyc - rel;
      chk(lat >= ALIGN && lat <= ALIGN + SYNC + 4, "R6 start latency", lat, ALIGN);
      chk(tot_trials - t0 == W, "R3 decision count", tot_trials - t0, W);
      chk(rise_val == (1 << (W - 1)), "R3 first trial", rise_val, 1 << (W - 1));
      chk(intr_n == 1'b0, "R8 interrupt low", int'(intr_n), 0);
      bus_read(v, oe);
      chk(oe == 1'b1, "R7 oe during read", int'(oe), 1);
      chk(int'(v) == exp_code(a), "R2 result", int'(v), exp_code(a));
      #1;
      chk(data_oe == 1'b0 && data_out == '0, "R7 idle bus", int'(data_out), 0);
   endtask

   task automatic t_read_clear();
      cs_n = 1'b1; rd_n = 1'b0;
      repeat (5) @(negedge clk); #1;
      chk(intr_n == 1'b0, "R9 read without cs", int'(intr_n), 0);
      chk(data_oe == 1'b0 && data_out == '0, "R7 rd without cs", int'(data_out), 0);
      rd_n = 1'b1;
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0;
      repeat (SYNC + 2) @(negedge clk); #1;
      chk(intr_n == 1'b1, "R9 read clears", int'(intr_n), 1);
      rd_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic t_no_cs_start();
      int t0;
      t_convert(400);
      t0 = tot_trials;
      @(negedge clk);
      cs_n = 1'b1; wr_drv = 1'b0;
      repeat (5) @(negedge clk);
      wr_drv = 1'b1;
      repeat (30) @(negedge clk); #1;
      chk(tot_trials == t0, "R5 no trials", tot_trials - t0, 0);
      chk(intr_n == 1'b0, "R5 interrupt unchanged", int'(intr_n), 0);
   endtask

   task automatic t_long_hold();
      int t0;
      logic [W-1:0] v; logic oe;
      ana = 700;
      t0 = tot_trials;
      @(negedge clk);
      cs_n = 1'b0; wr_drv = 1'b0;
      repeat (40) @(negedge clk); #1;
      chk(tot_trials == t0, "R4 no decisions in hold", tot_trials - t0, 0);
      chk(trial_code == '0, "R4 trial zero in hold", int'(trial_code), 0);
      chk(intr_n == 1'b1, "R10 arming clears interrupt", int'(intr_n), 1);
      wr_drv = 1'b1; cs_n = 1'b1;
      wait_intr_low("R4 conversion after hold");
      bus_read(v, oe);
      chk(int'(v) == exp_code(700), "R4 result after hold", int'(v), exp_code(700));
   endtask

   task automatic t_abort();
      logic [W-1:0] v; logic oe;
      t_convert(100);
      ana = 800;
      arm_release(4);
      repeat (ALIGN + SYNC + 4) @(negedge clk); #1;
      chk(trial_code != '0, "R11 inside search", int'(trial_code), 1);
      bus_read(v, oe);
      chk(int'(v) == exp_code(100), "R11 old code mid search", int'(v), exp_code(100));
      cs_n = 1'b0; wr_drv = 1'b0;
      repeat (4) @(negedge clk);
      rd_n = 1'b0; #1;
      chk(int'(data_out) == exp_code(100), "R11 old code during restart",
          int'(data_out), exp_code(100));
      chk(intr_n == 1'b1, "R11 no interrupt for aborted search", int'(intr_n), 1);
      rd_n = 1'b1;
      wr_drv = 1'b1; cs_n = 1'b1;
      wait_intr_low("R11 restarted conversion");
      bus_read(v, oe);
      chk(int'(v) == exp_code(800), "R11 new code", int'(v), exp_code(800));
   endtask

   task automatic t_free_run();
      int vals[6] = '{0, 1023, 301, 512, 77, 642};
      ana = vals[0];
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b1; sa_mode = 1'b1; kick_n = 1'b0;
      repeat (4) @(negedge clk);
      kick_n = 1'b1;
      for (int k = 0; k < 6; k++) begin
         bit hi = 1'b0;
         for (int i = 0; i < 300 && !hi; i++) begin
            @(negedge clk);
            if (intr_n == 1'b1) hi = 1'b1;
         end
         wait_intr_low("R12 free-run interrupt");
         rd_n = 1'b0; #1;
         chk(int'(data_out) == exp_code(vals[k]), "R12 free-run code",
             int'(data_out), exp_code(vals[k]));
         rd_n = 1'b1;
         if (k < 5) ana = vals[k + 1];
      end
      sa_mode = 1'b0; cs_n = 1'b1; wr_drv = 1'b1;
      repeat (40) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_convert(0);
      t_convert(1023);
      t_convert(2);
      t_convert(1);
      t_convert(514);
      t_convert(513);
      t_read_clear();
      t_no_cs_start();
      t_long_hold();
      t_abort();
      t_free_run();
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(WD * 8);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule